// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block lets synchronous logic use an external asynchronous static RAM of 524,288 words by 32 bits. A requester hands it one single-beat read or write at a time over a valid/ready handshake. Each request carries a 19-bit word address, a 32-bit write word and a 4-bit lane mask. The controller turns the request into the memory's active-low strobes: three chip enables that always switch together, write enable, output enable and four byte-lane enables. It also drives a tri-state enable for the shared data bus.

Each access is held for a fixed number of clock cycles. That number comes from the memory's 10 ns address-to-data time and the clock period, as ceil(10 ns / period) plus one cycle of margin. At 250 MHz this is 4 cycles. A write wraps its write-enable pulse in one setup cycle and one hold cycle, and the bus is released in both. A read keeps the address, lane enables and output enable steady for the full wait, then registers the returned word and zeroes the lanes that were masked off.

The state machine has five states. ST_IDLE is the resting state with the handshake open. ST_WR_SETUP is the write address and lane setup cycle. ST_WR_PULSE is the write-enable pulse. ST_WR_HOLD is the strobe release cycle. ST_RD_WAIT is the read access wait. Its transitions are:
- accept-write: ST_IDLE to ST_WR_SETUP.
- accept-read: ST_IDLE to ST_RD_WAIT.
- setup-done: ST_WR_SETUP to ST_WR_PULSE.
- pulse-done: ST_WR_PULSE to ST_WR_HOLD, when the timer expires.
- hold-done: ST_WR_HOLD to ST_IDLE.
- read-done: ST_RD_WAIT to ST_IDLE, when the timer expires and the data is captured.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no request is in progress, `req_ready` is 1, `mem_ce_n` is 3'b111, `mem_we_n`, `mem_oe_n` and all four `mem_be_n` bits are 1, and `mem_dq_oe` is 0.
- R2: In a write, all three chip enables are low together, and `mem_we_n` is low for exactly ACC_CYC consecutive cycles (4 at defaults). During that pulse `mem_dq_out` carries the write word. The three chip enables are always either all low or all high.
- R3: `mem_dq_oe` is 1 only while `mem_we_n` is 0. The cycle before write enable falls and the cycle after it rises both have `mem_dq_oe` at 0, so the controller and the memory never drive the bus in the same cycle.
- R4: In a read, the chip enables and `mem_oe_n` are low, and `mem_we_n` stays high with the bus released. Address and lane enables stay unchanged for ACC_CYC cycles before the data is sampled.
- R5: A lane whose mask bit is 0 keeps its byte enable high. A write leaves that lane's stored byte unchanged, and a read returns 8'h00 in it.
- R6: Mask bit i controls `mem_be_n[i]` and data bits [8i+7:8i]. Bit 0 covers bits 7:0, bit 1 covers 15:8, bit 2 covers 23:16 and bit 3 covers 31:24.
- R7: `req_ready` goes low on the cycle after a request is accepted. It returns high when a read's `rsp_valid` pulses or when a write's hold cycle ends. `rsp_valid` is a one-cycle pulse that appears together with `rsp_rdata`.
- R8: `mem_oe_n` stays high during every write phase and while idle.
- R9: A read returns `req_ready` and `rsp_valid` ACC_CYC clock edges after the accepting edge. A write returns `req_ready` ACC_CYC+2 edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write word |
| req_mask | input | 4 | Lane mask, bit i selects bits [8i+7:8i] |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 32 | Read word, masked lanes zero |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 3 | Active-low chip enables |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 4 | Active-low byte-lane enables |
| mem_dq_out | output | 32 | Data driven onto the bus |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_out` |
| mem_dq_in | input | 32 | Data returned from the bus |

## Verification
The controller is tried with full-mask writes and reads, writes to a single lane followed by full reads, reads with an empty mask, and a long random mix of reads and writes with random masks over a small address pool. Single-lane writes over a known word separate a correct lane mapping from a swapped or shifted one. Empty-mask reads show whether masked lanes are zeroed or pass through the bus noise. The memory model only returns real data once the address has been steady for three cycles, and it drives noise on disabled lanes, so a shortened wait or a wrong strobe changes the returned word. The random mix with revisited addresses shows whether untouched lanes survive partial writes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_WAIT
    } ctrl_state_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == TOP);
endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    active,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] raw_data,
    output logic [LANES-1:0]        be_n,
    output logic [LANES*LANE_W-1:0] kept_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_n[i] = ~(active & mask[i]);
        assign kept_data[i*LANE_W +: LANE_W] =
            mask[i] ? raw_data[i*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 32,
    parameter int LANE_W    = 8,
    parameter int CE_COUNT  = 3,
    parameter int CLK_PS    = 4000,
    parameter int ACCESS_PS = 10000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [DATA_W/LANE_W-1:0]   req_mask,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [CE_COUNT-1:0]        mem_ce_n,
    output logic                       mem_we_n,
    output logic                       mem_oe_n,
    output logic [DATA_W/LANE_W-1:0]   mem_be_n,
    output logic [DATA_W-1:0]          mem_dq_out,
    output logic                       mem_dq_oe,
    input  logic [DATA_W-1:0]          mem_dq_in
);
    import sram_lane_pkg::*;

    localparam int LANES   = DATA_W / LANE_W;
    localparam int ACC_CYC = (ACCESS_PS + CLK_PS - 1) / CLK_PS + 1;

    ctrl_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              accept;
    logic              timer_last;
    logic              ce_act, we_act, oe_act, lane_act, drive, capture;
    logic [DATA_W-1:0] kept_data;

    assign accept = req_valid && req_ready;

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_WAIT;
            ST_WR_SETUP: state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (timer_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            ST_RD_WAIT:  if (timer_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        req_ready = 1'b0;
        ce_act    = 1'b0;
        we_act    = 1'b0;
        oe_act    = 1'b0;
        lane_act  = 1'b0;
        drive     = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                ce_act   = 1'b1;
                lane_act = 1'b1;
            end
            ST_WR_PULSE: begin
                ce_act   = 1'b1;
                lane_act = 1'b1;
                we_act   = 1'b1;
                drive    = 1'b1;
            end
            ST_RD_WAIT: begin
                ce_act   = 1'b1;
                lane_act = 1'b1;
                oe_act   = 1'b1;
                capture  = timer_last;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    sram_phase_timer #(.LIMIT(ACC_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q != state_d),
        .last    (timer_last)
    );

    sram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .active    (lane_act),
        .mask      (mask_q),
        .raw_data  (mem_dq_in),
        .be_n      (mem_be_n),
        .kept_data (kept_data)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (kept_data),
        .valid   (rsp_valid),
        .dout    (rsp_rdata)
    );

    assign mem_addr   = addr_q;
    assign mem_ce_n   = {CE_COUNT{~ce_act}};
    assign mem_we_n   = ~we_act;
    assign mem_oe_n   = ~oe_act;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = drive;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W   = 19,
    parameter int LANES    = 4,
    parameter int CE_COUNT = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [CE_COUNT-1:0] mem_ce_n,
    input logic                mem_we_n,
    input logic                mem_oe_n,
    input logic [LANES-1:0]    mem_be_n,
    input logic                mem_dq_oe
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n == {CE_COUNT{1'b1}}) && mem_we_n && mem_oe_n
                      && (mem_be_n == {LANES{1'b1}}) && !mem_dq_oe);

    p_ce_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n == '0) || (mem_ce_n == {CE_COUNT{1'b1}}));

    p_drive_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    p_release_before_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !$past(mem_dq_oe));

    p_release_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    p_read_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe && (mem_ce_n == '0)));

    p_oe_off_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W(ADDR_W), .LANES(DATA_W / LANE_W), .CE_COUNT(CE_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    localparam int ACC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic [2:0]  mem_ce_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  mem_be_n;
    logic [31:0] mem_dq_out;
    logic [31:0] mem_dq_in = 32'hA5A5A5A5;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model and bench reference share only the power-up contents
    logic [31:0] store [int];
    logic [31:0] shadow [int];
    int          stab = 0;
    logic [18:0] last_addr = '0;
    int          contention = 0;
    int          oe_in_write = 0;
    int          bad_pulse = 0;
    int          we_run = 0;

    function automatic logic [31:0] initial_word(logic [18:0] a);
        return {a[12:0], a} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] nw,
                                               logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] lane_keep(logic [31:0] w, logic [3:0] m);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = w[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] store_rd(logic [18:0] a);
        if (store.exists(int'(a))) return store[int'(a)];
        return initial_word(a);
    endfunction

    function automatic logic [31:0] shadow_rd(logic [18:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return initial_word(a);
    endfunction

    wire reading = (mem_ce_n == 3'b000) && !mem_oe_n && mem_we_n;

    always @(posedge clk) begin
        if (reading && mem_addr == last_addr) stab <= stab + 1;
        else stab <= reading ? 1 : 0;
        last_addr <= mem_addr;
        if (mem_ce_n == 3'b000 && !mem_we_n && mem_dq_oe)
            store[int'(mem_addr)] = lane_merge(store_rd(mem_addr), mem_dq_out, ~mem_be_n);
        if (mem_dq_oe && reading && mem_be_n != 4'hF) contention++;
        if (!mem_we_n && !mem_oe_n) oe_in_write++;
        if (!mem_we_n) we_run <= we_run + 1;
        else begin
            if (we_run != 0 && we_run != ACC) bad_pulse++;
            we_run <= 0;
        end
    end

    always @(negedge clk) begin
        logic [31:0] w;
        w = 32'hA5A5A5A5;
        if (reading) begin
            if (stab >= 3) begin
                for (int i = 0; i < 4; i++)
                    if (!mem_be_n[i]) w[i*8 +: 8] = store_rd(mem_addr) >> (i*8);
            end else begin
                w = 32'h0BAD0BAD;
            end
        end
        mem_dq_in = w;
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_op(bit wr, logic [18:0] a, logic [31:0] d, logic [3:0] m);
        int lat = 0;
        bit ready_low;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = $urandom;
        req_wdata = $urandom;
        req_mask  = 4'($urandom);
        ready_low = !req_ready;
        while (!req_ready) begin
            if (rsp_valid) ready_low = 1'b0;
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R7 ready low after accept", 32'(ready_low), 32'd1);
        if (wr) begin
            shadow[int'(a)] = lane_merge(shadow_rd(a), d, m);
            check("R9 write latency", lat, ACC + 2);
        end else begin
            check("R9 read latency", lat, ACC);
            check("R7 rsp_valid with ready", 32'(rsp_valid), 32'd1);
            check("R4/R5/R6 read data", rsp_rdata, lane_keep(shadow_rd(a), m));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset pins", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
              {1'b1, 3'b111, 1'b1, 1'b1, 4'hF, 1'b0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle pins", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
              {1'b1, 3'b111, 1'b1, 1'b1, 4'hF, 1'b0});

        // Directed: full write and read
        do_op(1, 19'h00010, 32'h1122_3344, 4'hF);
        do_op(0, 19'h00010, 32'h0, 4'hF);
        // R6: each lane alone over a known word
        for (int i = 0; i < 4; i++) begin
            do_op(1, 19'h00020, 32'h0, 4'hF);
            do_op(1, 19'h00020, 32'hFFFF_FFFF, 4'(1 << i));
            do_op(0, 19'h00020, 32'h0, 4'hF);
        end
        // R5: empty-mask read returns zero, empty-mask write keeps data
        do_op(0, 19'h00010, 32'h0, 4'h0);
        do_op(1, 19'h00010, 32'hDEAD_BEEF, 4'h0);
        do_op(0, 19'h00010, 32'h0, 4'hF);
        // R5: partial read keeps only selected lanes
        do_op(0, 19'h7FFFF, 32'h0, 4'b1010);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            do_op(1'($urandom), 19'h40000 + 19'($urandom % 16), $urandom, 4'($urandom));
        end

        @(negedge clk);
        check("R1 idle after traffic", {req_ready, mem_ce_n, mem_oe_n, mem_dq_oe},
              {1'b1, 3'b111, 1'b1, 1'b0});
        check("R3 no bus contention", contention, 0);
        check("R8 oe high during write", oe_in_write, 0);
        check("R2 write pulse length", bad_pulse, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule